// File: doc/BRIEF.md
# Programmable Raster Timing Generator with Interlace Support

The block walks a raster of pixels and lines from a set of programmable timing values and produces horizontal sync, vertical sync and a data-enable strobe, together with the running pixel and line positions and a field indicator. Each line begins with its active pixels and is followed by horizontal blanking. The sync pulse starts a programmed offset after the end of the active area. Vertical timing has the same structure in units of lines. The offset equals the front porch, and the blanking total is front porch plus sync width plus back porch.

An interlaced mode treats every programmed vertical value as a per-field quantity. Fields alternate between field 0 and field 1, and the vertical sync of field 1 is moved half a line later. When the frame's vertical blanking is odd, a flag gives field 1 one more blanking line than field 0. A pixel-repetition mode doubles every horizontal quantity. Each sync output and the data-enable output has its own polarity bit. The timing values are captured into shadow registers on the first cycle after reset and again at each frame boundary, so software can rewrite them at any time without breaking a frame.

Top module: `video_timing_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, pix_cnt_o, line_cnt_o and field_o are 0 and hsync_o, vsync_o and de_o are all low.
- R2: pix_cnt_o counts from 0 to H_tot-1 and then wraps to 0. H_tot is the horizontal active count plus the horizontal blanking count. line_cnt_o advances by one at each pixel wrap and returns to 0 after the last line of a field.
- R3: The internal data-enable is active when pix_cnt_o is below the horizontal active count and line_cnt_o is below the vertical active count.
- R4: The internal hsync is active when pix_cnt_o lies in [h_act + h_off, h_act + h_off + h_wid).
- R5: In progressive mode, and in field 0 of interlaced mode, the internal vsync is active on the lines in [v_act + v_off, v_act + v_off + v_wid), and its edges fall at pixel 0.
- R6: A polarity bit of 1 drives the matching output high when it is active. A polarity bit of 0 drives it low when it is active. The three polarity bits are independent.
- R7: With pix_rep_i = 1, the horizontal active, blanking, sync offset and sync width values are each doubled.
- R8: In interlaced mode, field_o is 0 in the first field of a frame and 1 in the second field, and changes only at a field boundary. In progressive mode it stays 0.
- R9: In interlaced mode with vb_odd_i = 1, field 1 has v_blank + 1 blanking lines and field 0 has v_blank. In progressive mode, vb_odd_i has no effect on the line count.
- R10: In field 1 of interlaced mode, the vsync window of R5 is delayed by floor(H_tot/2) pixels, so its edges fall at that pixel position.
- R11: Timing values, polarities and mode bits are sampled only in the first cycle after reset and at the last pixel of a frame. A change made in the middle of a frame has no effect until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_active_i | input | 13 | Active pixels per line |
| h_blank_i | input | 13 | Blanking pixels per line |
| h_off_i | input | 13 | Hsync start after end of active (front porch) |
| h_wid_i | input | 10 | Hsync width in pixels |
| v_active_i | input | 13 | Active lines per field |
| v_blank_i | input | 8 | Blanking lines per field |
| v_off_i | input | 8 | Vsync start after end of active lines |
| v_wid_i | input | 6 | Vsync width in lines |
| hs_pol_i | input | 1 | Hsync polarity, 1 = active high |
| vs_pol_i | input | 1 | Vsync polarity, 1 = active high |
| de_pol_i | input | 1 | Data-enable polarity, 1 = active high |
| ilace_i | input | 1 | Interlaced mode |
| vb_odd_i | input | 1 | Extra blanking line in field 1 (interlaced only) |
| pix_rep_i | input | 1 | Double all horizontal values |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_cnt_o | output | 16 | Pixel position in line |
| line_cnt_o | output | 14 | Line position in field |
| field_o | output | 1 | Current field |

## Verification
The generator is run through several configurations in turn:
- A plain progressive raster confirms the counter wrap points and the placement of the three windows.
- Clearing all polarity bits in the middle of a frame separates the inversion of each output from the frame-boundary sampling.
- Pixel repetition shows whether every horizontal quantity is doubled, or only some of them.
- Interlaced runs with the odd-blanking flag set and cleared distinguish the per-field line totals and the half-line vsync shift.
- A progressive run with the odd flag set shows that the flag is ignored outside interlaced mode.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  parameter int H_W  = 13;
  parameter int HS_W = 10;
  parameter int V_W  = 13;
  parameter int VB_W = 8;
  parameter int VS_W = 6;
  localparam int HC_W = H_W + 3;
  localparam int VC_W = V_W + 1;

  typedef struct packed {
    logic [H_W-1:0]  h_active;
    logic [H_W-1:0]  h_blank;
    logic [H_W-1:0]  h_off;
    logic [HS_W-1:0] h_wid;
    logic [V_W-1:0]  v_active;
    logic [VB_W-1:0] v_blank;
    logic [VB_W-1:0] v_off;
    logic [VS_W-1:0] v_wid;
    logic            hs_pol;
    logic            vs_pol;
    logic            de_pol;
    logic            ilace;
    logic            vb_odd;
    logic            pix_rep;
  } vtg_cfg_t;
endpackage

// File: rtl/vtg_shadow.sv
module vtg_shadow
  import vtg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  vtg_cfg_t cfg_i,
  output vtg_cfg_t cfg_o
);
  vtg_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;

  assert_cfg_frame_sync_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q) |-> $past(load_i));
endmodule

// File: rtl/vtg_hcount.sv
module vtg_hcount
  import vtg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [H_W-1:0]  h_active_i,
  input  logic [H_W-1:0]  h_blank_i,
  input  logic [H_W-1:0]  h_off_i,
  input  logic [HS_W-1:0] h_wid_i,
  input  logic            rep_i,
  output logic [HC_W-1:0] pix_o,
  output logic            line_end_o,
  output logic            de_h_o,
  output logic            hs_raw_o,
  output logic            second_half_o
);
  logic [HC_W-1:0] pix_q, act_e, tot_e, hs_s, hs_e, half_e;

  // pixel repetition scales every horizontal quantity
  always_comb begin
    act_e  = HC_W'(h_active_i) << rep_i;
    tot_e  = act_e + (HC_W'(h_blank_i) << rep_i);
    hs_s   = act_e + (HC_W'(h_off_i) << rep_i);
    hs_e   = hs_s + (HC_W'(h_wid_i) << rep_i);
    half_e = tot_e >> 1;
  end

  assign line_end_o    = run_i && (pix_q == tot_e - 1'b1);
  assign de_h_o        = pix_q < act_e;
  assign hs_raw_o      = run_i && (pix_q >= hs_s) && (pix_q < hs_e);
  assign second_half_o = pix_q >= half_e;
  assign pix_o         = pix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pix_q <= '0;
    else if (!run_i || line_end_o)  pix_q <= '0;
    else                            pix_q <= pix_q + 1'b1;
  end

  assert_pix_in_line_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> pix_q < tot_e);
  assert_pix_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end_o |=> pix_q == '0);
endmodule

// File: rtl/vtg_vcount.sv
module vtg_vcount
  import vtg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            line_end_i,
  input  logic            second_half_i,
  input  logic [V_W-1:0]  v_active_i,
  input  logic [VB_W-1:0] v_blank_i,
  input  logic [VB_W-1:0] v_off_i,
  input  logic [VS_W-1:0] v_wid_i,
  input  logic            ilace_i,
  input  logic            vb_odd_i,
  output logic [VC_W-1:0] line_o,
  output logic            field_o,
  output logic            frame_end_o,
  output logic            de_v_o,
  output logic            vs_raw_o
);
  logic [VC_W-1:0] line_q, tot_e, vs_s, vs_e, prev_l;
  logic            field_q, field_end, in_cur, in_prev;

  always_comb begin
    tot_e  = VC_W'(v_active_i) + VC_W'(v_blank_i)
           + VC_W'(ilace_i && vb_odd_i && field_q);
    vs_s   = VC_W'(v_active_i) + VC_W'(v_off_i);
    vs_e   = vs_s + VC_W'(v_wid_i);
    prev_l = line_q - 1'b1;
  end

  assign field_end   = line_end_i && (line_q == tot_e - 1'b1);
  assign frame_end_o = field_end && (!ilace_i || field_q);
  assign in_cur      = (line_q >= vs_s) && (line_q < vs_e);
  assign in_prev     = (line_q != '0) && (prev_l >= vs_s) && (prev_l < vs_e);
  // field 1 vsync lags by half a line
  assign vs_raw_o    = run_i && ((ilace_i && field_q && !second_half_i) ? in_prev : in_cur);
  assign de_v_o      = line_q < VC_W'(v_active_i);
  assign line_o      = line_q;
  assign field_o     = field_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      field_q <= 1'b0;
    end else if (!run_i) begin
      line_q  <= '0;
      field_q <= 1'b0;
    end else if (field_end) begin
      line_q  <= '0;
      field_q <= ilace_i && !field_q;
    end else if (line_end_i) begin
      line_q  <= line_q + 1'b1;
    end
  end

  assert_line_in_field_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> line_q < tot_e);
  assert_field_at_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(field_q) |-> $past(field_end));
  assert_prog_field_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_end && !ilace_i) |=> !field_q);
endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
  import vtg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [H_W-1:0]  h_active_i,
  input  logic [H_W-1:0]  h_blank_i,
  input  logic [H_W-1:0]  h_off_i,
  input  logic [HS_W-1:0] h_wid_i,
  input  logic [V_W-1:0]  v_active_i,
  input  logic [VB_W-1:0] v_blank_i,
  input  logic [VB_W-1:0] v_off_i,
  input  logic [VS_W-1:0] v_wid_i,
  input  logic            hs_pol_i,
  input  logic            vs_pol_i,
  input  logic            de_pol_i,
  input  logic            ilace_i,
  input  logic            vb_odd_i,
  input  logic            pix_rep_i,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            de_o,
  output logic [HC_W-1:0] pix_cnt_o,
  output logic [VC_W-1:0] line_cnt_o,
  output logic            field_o
);
  vtg_cfg_t cfg_in, cfg;
  logic run_q, load, frame_end, line_end, second_half;
  logic de_h, de_v, hs_raw, vs_raw;

  always_comb begin
    cfg_in.h_active = h_active_i;
    cfg_in.h_blank  = h_blank_i;
    cfg_in.h_off    = h_off_i;
    cfg_in.h_wid    = h_wid_i;
    cfg_in.v_active = v_active_i;
    cfg_in.v_blank  = v_blank_i;
    cfg_in.v_off    = v_off_i;
    cfg_in.v_wid    = v_wid_i;
    cfg_in.hs_pol   = hs_pol_i;
    cfg_in.vs_pol   = vs_pol_i;
    cfg_in.de_pol   = de_pol_i;
    cfg_in.ilace    = ilace_i;
    cfg_in.vb_odd   = vb_odd_i;
    cfg_in.pix_rep  = pix_rep_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  assign load = !run_q || frame_end;

  vtg_shadow u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg)
  );

  vtg_hcount u_hcount (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (run_q),
    .h_active_i    (cfg.h_active),
    .h_blank_i     (cfg.h_blank),
    .h_off_i       (cfg.h_off),
    .h_wid_i       (cfg.h_wid),
    .rep_i         (cfg.pix_rep),
    .pix_o         (pix_cnt_o),
    .line_end_o    (line_end),
    .de_h_o        (de_h),
    .hs_raw_o      (hs_raw),
    .second_half_o (second_half)
  );

  vtg_vcount u_vcount (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (run_q),
    .line_end_i    (line_end),
    .second_half_i (second_half),
    .v_active_i    (cfg.v_active),
    .v_blank_i     (cfg.v_blank),
    .v_off_i       (cfg.v_off),
    .v_wid_i       (cfg.v_wid),
    .ilace_i       (cfg.ilace),
    .vb_odd_i      (cfg.vb_odd),
    .line_o        (line_cnt_o),
    .field_o       (field_o),
    .frame_end_o   (frame_end),
    .de_v_o        (de_v),
    .vs_raw_o      (vs_raw)
  );

  assign hsync_o = run_q && (hs_raw == cfg.hs_pol);
  assign vsync_o = run_q && (vs_raw == cfg.vs_pol);
  assign de_o    = run_q && ((de_h && de_v) == cfg.de_pol);

  assert_idle_outputs_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (!hsync_o && !vsync_o && !de_o && pix_cnt_o == '0));
  assert_frame_start_origin_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |=> (pix_cnt_o == '0 && line_cnt_o == '0 && !field_o));
endmodule

// File: tb/video_timing_gen_tb.sv
module video_timing_gen_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [12:0] h_active_i, h_blank_i, h_off_i, v_active_i;
  logic [9:0]  h_wid_i;
  logic [7:0]  v_blank_i, v_off_i;
  logic [5:0]  v_wid_i;
  logic hs_pol_i, vs_pol_i, de_pol_i, ilace_i, vb_odd_i, pix_rep_i;
  logic hsync_o, vsync_o, de_o, field_o;
  logic [15:0] pix_cnt_o;
  logic [13:0] line_cnt_o;

  int n_chk = 0, n_fail = 0;
  string ph = "R1";

  // behavioural model state
  int  m_run = 0, m_pc = 0, m_lc = 0, m_fld = 0;
  int  s_ha, s_hb, s_ho, s_hw, s_va, s_vb, s_vo, s_vw;
  int  s_hp, s_vp, s_dp, s_il, s_od, s_rp;

  always #5 clk_i = ~clk_i;

  video_timing_gen dut_i (.*);

  task automatic chk(string sig, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", ph, sig, act, exp, $time);
    end
  endtask

  function automatic int htot();
    return (s_ha + s_hb) * (s_rp ? 2 : 1);
  endfunction
  function automatic int vtot();
    return s_va + s_vb + ((s_il && s_od && m_fld == 1) ? 1 : 0);
  endfunction
  function automatic int in_vs(int l);
    return (l >= s_va + s_vo && l < s_va + s_vo + s_vw) ? 1 : 0;
  endfunction

  always @(negedge clk_i) begin
    int k, e_de, e_hs, e_vs, raw;
    if (!rst_ni) begin
      m_run = 0; m_pc = 0; m_lc = 0; m_fld = 0;
      chk("R1 pix", pix_cnt_o, 0);
      chk("R1 line", line_cnt_o, 0);
      chk("R1 outs", {hsync_o, vsync_o, de_o, field_o}, 0);
    end else if (!m_run) begin
      chk("R1 pix", pix_cnt_o, 0);
      chk("R1 line", line_cnt_o, 0);
      chk("R1 outs", {hsync_o, vsync_o, de_o, field_o}, 0);
      s_ha = h_active_i; s_hb = h_blank_i; s_ho = h_off_i; s_hw = h_wid_i;
      s_va = v_active_i; s_vb = v_blank_i; s_vo = v_off_i; s_vw = v_wid_i;
      s_hp = hs_pol_i; s_vp = vs_pol_i; s_dp = de_pol_i;
      s_il = ilace_i; s_od = vb_odd_i; s_rp = pix_rep_i;
      m_run = 1;
    end else begin
      k = s_rp ? 2 : 1;
      raw  = (m_pc < s_ha * k && m_lc < s_va) ? 1 : 0;
      e_de = s_dp ? raw : 1 - raw;
      raw  = (m_pc >= (s_ha + s_ho) * k && m_pc < (s_ha + s_ho + s_hw) * k) ? 1 : 0;
      e_hs = s_hp ? raw : 1 - raw;
      if (s_il && m_fld == 1 && m_pc < htot() / 2)
        raw = (m_lc > 0) ? in_vs(m_lc - 1) : 0;
      else
        raw = in_vs(m_lc);
      e_vs = s_vp ? raw : 1 - raw;
      chk("R2 pix", pix_cnt_o, m_pc);
      chk("R2 line", line_cnt_o, m_lc);
      chk("R8 field", field_o, m_fld);
      chk("R3 R6 de", de_o, e_de);
      chk("R4 R6 hsync", hsync_o, e_hs);
      chk("R5 R10 vsync", vsync_o, e_vs);
      // advance to next cycle
      if (m_pc == htot() - 1) begin
        m_pc = 0;
        if (m_lc == vtot() - 1) begin
          int fe;
          fe = (!s_il || m_fld == 1) ? 1 : 0;
          m_lc = 0;
          m_fld = (s_il && m_fld == 0) ? 1 : 0;
          if (fe) begin
            s_ha = h_active_i; s_hb = h_blank_i; s_ho = h_off_i; s_hw = h_wid_i;
            s_va = v_active_i; s_vb = v_blank_i; s_vo = v_off_i; s_vw = v_wid_i;
            s_hp = hs_pol_i; s_vp = vs_pol_i; s_dp = de_pol_i;
            s_il = ilace_i; s_od = vb_odd_i; s_rp = pix_rep_i;
          end
        end else m_lc++;
      end else m_pc++;
    end
  end

  task automatic cycles(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic set_cfg(int ha, int hb, int ho, int hw, int va, int vb, int vo, int vw,
                         int pol, int il, int od, int rp);
    h_active_i = 13'(ha); h_blank_i = 13'(hb); h_off_i = 13'(ho); h_wid_i = 10'(hw);
    v_active_i = 13'(va); v_blank_i = 8'(vb); v_off_i = 8'(vo); v_wid_i = 6'(vw);
    hs_pol_i = pol[0]; vs_pol_i = pol[1]; de_pol_i = pol[2];
    ilace_i = il[0]; vb_odd_i = od[0]; pix_rep_i = rp[0];
  endtask

  initial begin
    set_cfg(8, 6, 2, 3, 4, 3, 1, 1, 7, 0, 0, 0);
    cycles(6);
    rst_ni = 1'b1;
    ph = "R2 R3 R4 R5";
    cycles(250);
    ph = "R6 R11";                              // change mid-frame, all polarities low
    set_cfg(8, 6, 2, 3, 4, 3, 1, 1, 0, 0, 0, 0);
    cycles(300);
    ph = "R6 R7";                               // mixed polarity, repetition on
    set_cfg(6, 5, 1, 2, 3, 4, 2, 2, 5, 0, 0, 1);
    cycles(600);
    ph = "R8 R9 R10";                           // interlaced, odd blanking
    set_cfg(8, 7, 2, 3, 4, 3, 1, 2, 7, 1, 1, 0);
    cycles(900);
    ph = "R8 R10";                              // interlaced, even blanking
    set_cfg(9, 7, 1, 2, 3, 4, 2, 1, 3, 1, 0, 0);
    cycles(700);
    ph = "R9 R11";                              // odd flag ignored in progressive
    set_cfg(7, 5, 1, 2, 4, 3, 0, 2, 7, 0, 1, 0);
    cycles(500);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog R2 act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule